// File: doc/BRIEF.md
# Banked Interrupt Group Register File

This block is the storage slice of an interrupt distributor that records which group each interrupt line belongs to. It keeps one bit per interrupt. A 0 places the interrupt in group 0, which is the secure, higher-priority class. A 1 places it in group 1, which is the non-secure, lower-priority class. Software reaches the bits through a byte-wide register window. Window byte k holds the eight interrupts whose IDs run from 8k to 8k+7, and bit i of that byte belongs to ID 8k+i. Each access carries a secure attribute and the index of the requesting CPU.

The first 32 interrupt IDs are private to each CPU, so every CPU has its own copy of their group bits. Interrupts from ID 32 upward are shared and have a single copy. Whether the window is live at all depends on build-time parameters. Grouping exists only when the revision parameter is 2 or the security extension is enabled. With the security extension enabled, a non-secure access sees a window that reads as zero and ignores writes. The full set of group bits is exported per CPU for downstream routing logic.

Top module: `irq_group_bank`

## Requirements
- R1: Under synchronous reset every group bit of every CPU copy is 0, so `grp_o` is all zeros on the cycle after a reset edge.
- R2: A live write to window byte k loads `acc_wdata[i]` as the group bit of ID 8k+i. A 1 selects group 1 and a 0 selects group 0. The value is visible on `grp_o` bit `c*N_IRQ + id` after the next rising clock edge.
- R3: A live read returns, in the same cycle, the stored group bits of IDs 8k..8k+7 in bit positions 0..7. When no read is presented, `acc_rdata` is zero.
- R4: With the security extension enabled, a non-secure access reads zero, changes no bit and raises no error, whatever its window byte is.
- R5: IDs 0 to 31 (window bytes 0 to 3) are banked per CPU. A write changes only the copy that `acc_cpu` selects, and a read returns that copy.
- R6: IDs 32 and up (window byte 4 onward) have a single copy. A write from any CPU is seen by every CPU on reads and on `grp_o`.
- R7: A live access whose first ID, 8k, is at or above `N_IRQ` raises `acc_err` only during that access. It reads zero and changes no bit.
- R8: When the revision is not 2 and the security extension is off, the whole window reads zero, ignores writes and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sec | input | 1 | Secure attribute of the access |
| acc_cpu | input | CPU_W | Index of the requesting CPU |
| acc_idx | input | 7 | Byte index inside the group window |
| acc_wdata | input | 8 | Write data, one group bit per interrupt |
| acc_rdata | output | 8 | Combinational read data |
| acc_err | output | 1 | Out-of-range access flag, valid with the access |
| grp_o | output | N_CPU*N_IRQ | Group bits per CPU; CPU c occupies bits c*N_IRQ upward |

## Verification
The bench builds the main instance with two CPUs, 64 interrupts, revision 2 and the security extension on. This setting has four private bytes and four shared bytes, so it covers banking across CPUs, visibility of shared bits, the first out-of-range byte (8), the last byte (127) and non-secure suppression. A second instance built with revision 1 and no security extension is driven by the same access stream, which exposes the case where grouping is absent altogether.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;

    localparam int PRIV_IRQS  = 32;
    localparam int PRIV_BYTES = PRIV_IRQS / 8;
    localparam int WIN_IDX_W  = 7;
    localparam int ID_W       = 10;

    // Decoded view of one access
    typedef struct packed {
        logic wr_ok;   // write that may update state
        logic rd_ok;   // read that returns stored bits
        logic err;     // first ID beyond the configured count
        logic priv;    // byte covers banked private IDs
    } acc_dec_t;

    function automatic logic groups_present(input int rev, input logic sec_ext);
        return (rev == 2) || sec_ext;
    endfunction

    function automatic logic [ID_W-1:0] first_id(input logic [WIN_IDX_W-1:0] idx);
        return {idx, 3'b000};
    endfunction

endpackage

// File: rtl/irqgrp_decode.sv
module irqgrp_decode
    import irqgrp_pkg::*;
#(
    parameter int   N_IRQ   = 64,
    parameter int   REV     = 2,
    parameter logic SEC_EXT = 1'b1
) (
    input  logic                 en,
    input  logic                 wr,
    input  logic                 sec,
    input  logic [WIN_IDX_W-1:0] idx,
    output acc_dec_t             dec
);
    localparam logic GROUPED = groups_present(REV, SEC_EXT);

    logic live;
    logic beyond;

    always_comb begin
        // Suppression checks come before the range check
        live   = en && GROUPED && !(SEC_EXT && !sec);
        beyond = first_id(idx) >= ID_W'(N_IRQ);
        dec.err   = live && beyond;
        dec.wr_ok = live && !beyond && wr;
        dec.rd_ok = live && !beyond && !wr;
        dec.priv  = idx < WIN_IDX_W'(PRIV_BYTES);
    end
endmodule

// File: rtl/irqgrp_priv_bank.sv
module irqgrp_priv_bank
    import irqgrp_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int CPU_W = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [CPU_W-1:0]         cpu,
    input  logic [1:0]               lane,
    input  logic [7:0]               wdata,
    output logic [N_CPU*PRIV_IRQS-1:0] bits
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        for (genvar l = 0; l < PRIV_BYTES; l++) begin : g_lane
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (we && cpu == CPU_W'(c) && lane == 2'(l))
                    byte_q <= wdata;
            end
            assign bits[c*PRIV_IRQS + l*8 +: 8] = byte_q;
        end
    end
endmodule

// File: rtl/irqgrp_shared_bank.sv
module irqgrp_shared_bank
    import irqgrp_pkg::*;
#(
    parameter int N_SHR = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [WIN_IDX_W-1:0] idx,
    input  logic [7:0]           wdata,
    output logic [N_SHR-1:0]     bits
);
    localparam int SHR_BYTES = N_SHR / 8;

    for (genvar b = 0; b < SHR_BYTES; b++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (we && idx == WIN_IDX_W'(PRIV_BYTES + b))
                byte_q <= wdata;
        end
        assign bits[b*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
    import irqgrp_pkg::*;
#(
    parameter int   N_CPU   = 2,
    parameter int   N_IRQ   = 64,
    parameter int   REV     = 2,
    parameter logic SEC_EXT = 1'b1,
    localparam int  CPU_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_en,
    input  logic                   acc_wr,
    input  logic                   acc_sec,
    input  logic [CPU_W-1:0]       acc_cpu,
    input  logic [6:0]             acc_idx,
    input  logic [7:0]             acc_wdata,
    output logic [7:0]             acc_rdata,
    output logic                   acc_err,
    output logic [N_CPU*N_IRQ-1:0] grp_o
);
    localparam int N_SHR     = N_IRQ - PRIV_IRQS;
    localparam int SHR_BYTES = N_SHR / 8;

    acc_dec_t                     dec;
    logic [N_CPU*PRIV_IRQS-1:0]   priv_bits;

    irqgrp_decode #(.N_IRQ(N_IRQ), .REV(REV), .SEC_EXT(SEC_EXT)) u_dec (
        .en(acc_en), .wr(acc_wr), .sec(acc_sec), .idx(acc_idx), .dec(dec)
    );

    irqgrp_priv_bank #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_priv (
        .clk(clk), .rst(rst), .we(dec.wr_ok && dec.priv), .cpu(acc_cpu),
        .lane(acc_idx[1:0]), .wdata(acc_wdata), .bits(priv_bits)
    );

    if (N_SHR > 0) begin : g_shr
        logic [N_SHR-1:0] shr_bits;

        irqgrp_shared_bank #(.N_SHR(N_SHR)) u_shr (
            .clk(clk), .rst(rst), .we(dec.wr_ok && !dec.priv), .idx(acc_idx),
            .wdata(acc_wdata), .bits(shr_bits)
        );

        for (genvar c = 0; c < N_CPU; c++) begin : g_out
            assign grp_o[c*N_IRQ + PRIV_IRQS +: N_SHR] = shr_bits;
        end

        always_comb begin
            acc_rdata = '0;
            if (dec.rd_ok) begin
                if (dec.priv) begin
                    for (int c = 0; c < N_CPU; c++)
                        if (acc_cpu == CPU_W'(c))
                            acc_rdata = priv_bits[c*PRIV_IRQS + {acc_idx[1:0], 3'b000} +: 8];
                end else begin
                    for (int b = 0; b < SHR_BYTES; b++)
                        if (acc_idx == 7'(PRIV_BYTES + b))
                            acc_rdata = shr_bits[b*8 +: 8];
                end
            end
        end
    end else begin : g_noshr
        always_comb begin
            acc_rdata = '0;
            if (dec.rd_ok)
                for (int c = 0; c < N_CPU; c++)
                    if (acc_cpu == CPU_W'(c))
                        acc_rdata = priv_bits[c*PRIV_IRQS + {acc_idx[1:0], 3'b000} +: 8];
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_priv_out
        assign grp_o[c*N_IRQ +: PRIV_IRQS] = priv_bits[c*PRIV_IRQS +: PRIV_IRQS];
    end

    assign acc_err = dec.err;
endmodule

// File: rtl/irqgrp_bank_chk.sv
module irqgrp_bank_chk
    import irqgrp_pkg::*;
#(
    parameter int   N_CPU   = 2,
    parameter int   N_IRQ   = 64,
    parameter int   REV     = 2,
    parameter logic SEC_EXT = 1'b1,
    parameter int   CPU_W   = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   acc_en,
    input logic                   acc_wr,
    input logic                   acc_sec,
    input logic [CPU_W-1:0]       acc_cpu,
    input logic [6:0]             acc_idx,
    input logic [7:0]             acc_rdata,
    input logic                   acc_err,
    input logic [N_CPU*N_IRQ-1:0] grp_o
);
    localparam logic GROUPED = groups_present(REV, SEC_EXT);

    logic [9:0] id0;
    assign id0 = {acc_idx, 3'b000};

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> grp_o == '0);

    p_ns_raz_r4: assert property (@(posedge clk) disable iff (rst)
        (SEC_EXT && acc_en && !acc_sec) |-> (acc_rdata == 8'h00 && !acc_err));

    p_ns_wi_r4: assert property (@(posedge clk) disable iff (rst)
        (SEC_EXT && acc_en && acc_wr && !acc_sec) |=> $stable(grp_o));

    p_err_range_r7: assert property (@(posedge clk) disable iff (rst)
        (GROUPED && acc_en && (acc_sec || !SEC_EXT) && id0 >= 10'(N_IRQ)) |-> acc_err);

    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> acc_rdata == 8'h00);

    p_err_keep_r7: assert property (@(posedge clk) disable iff (rst)
        acc_err |=> $stable(grp_o));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (acc_rdata == 8'h00 && !acc_err));

    p_nogroup_r8: assert property (@(posedge clk) disable iff (rst)
        !GROUPED |-> (grp_o == '0 && !acc_err && acc_rdata == 8'h00));

    for (genvar c = 0; c < N_CPU; c++) begin : g_bank
        p_bank_isolate_r5: assert property (@(posedge clk) disable iff (rst)
            (acc_en && acc_wr && acc_cpu != CPU_W'(c)) |=> $stable(grp_o[c*N_IRQ +: PRIV_IRQS]));
        if (c > 0 && N_IRQ > PRIV_IRQS) begin : g_shr
            p_shared_same_r6: assert property (@(posedge clk) disable iff (rst)
                grp_o[c*N_IRQ + PRIV_IRQS +: N_IRQ-PRIV_IRQS] == grp_o[PRIV_IRQS +: N_IRQ-PRIV_IRQS]);
        end
    end
endmodule

bind irq_group_bank irqgrp_bank_chk #(
    .N_CPU(N_CPU), .N_IRQ(N_IRQ), .REV(REV), .SEC_EXT(SEC_EXT), .CPU_W(CPU_W)
) chk_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sec(acc_sec),
    .acc_cpu(acc_cpu), .acc_idx(acc_idx), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .grp_o(grp_o)
);

// File: tb/irq_group_bank_tb_top.sv
module irq_group_bank_tb_top;
    localparam int N_CPU = 2;
    localparam int N_IRQ = 64;
    localparam int NV    = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_en = 1'b0, acc_wr = 1'b0, acc_sec = 1'b0;
    logic [0:0] acc_cpu = '0;
    logic [6:0] acc_idx = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd, ng_rd;
    logic err, ng_err;
    logic [N_CPU*N_IRQ-1:0] grp, ng_grp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_group_bank #(.N_CPU(N_CPU), .N_IRQ(N_IRQ), .REV(2), .SEC_EXT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sec(acc_sec),
        .acc_cpu(acc_cpu), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .acc_rdata(rd), .acc_err(err), .grp_o(grp)
    );

    irq_group_bank #(.N_CPU(N_CPU), .N_IRQ(N_IRQ), .REV(1), .SEC_EXT(1'b0)) dut_ng (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sec(acc_sec),
        .acc_cpu(acc_cpu), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .acc_rdata(ng_rd), .acc_err(ng_err), .grp_o(ng_grp)
    );

    typedef struct packed {
        logic       cpu;
        logic       sec;
        logic       wr;
        logic [6:0] idx;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic       exp_err;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 7'd0,   8'hA5, 8'h00, 1'b0, 4'd2},  // R2 write private byte, cpu0
        '{1'b0, 1'b1, 1'b0, 7'd0,   8'h00, 8'hA5, 1'b0, 4'd3},  // R3 read back
        '{1'b1, 1'b1, 1'b0, 7'd0,   8'h00, 8'h00, 1'b0, 4'd5},  // R5 cpu1 copy untouched
        '{1'b1, 1'b1, 1'b1, 7'd3,   8'h3C, 8'h00, 1'b0, 4'd5},  // R5 cpu1 writes IDs 24..31
        '{1'b1, 1'b1, 1'b0, 7'd3,   8'h00, 8'h3C, 1'b0, 4'd5},
        '{1'b0, 1'b1, 1'b0, 7'd3,   8'h00, 8'h00, 1'b0, 4'd5},  // R5 cpu0 copy untouched
        '{1'b0, 1'b1, 1'b1, 7'd4,   8'h81, 8'h00, 1'b0, 4'd6},  // R6 shared IDs 32..39
        '{1'b1, 1'b1, 1'b0, 7'd4,   8'h00, 8'h81, 1'b0, 4'd6},  // R6 seen by cpu1
        '{1'b1, 1'b1, 1'b1, 7'd7,   8'hFF, 8'h00, 1'b0, 4'd6},  // R6 last valid byte
        '{1'b0, 1'b1, 1'b0, 7'd7,   8'h00, 8'hFF, 1'b0, 4'd6},
        '{1'b0, 1'b0, 1'b1, 7'd4,   8'h00, 8'h00, 1'b0, 4'd4},  // R4 non-secure write
        '{1'b0, 1'b0, 1'b0, 7'd4,   8'h00, 8'h00, 1'b0, 4'd4},  // R4 non-secure read zero
        '{1'b0, 1'b1, 1'b0, 7'd4,   8'h00, 8'h81, 1'b0, 4'd4},  // R4 write was ignored
        '{1'b0, 1'b1, 1'b1, 7'd8,   8'hFF, 8'h00, 1'b1, 4'd7},  // R7 first byte beyond
        '{1'b0, 1'b1, 1'b0, 7'd8,   8'h00, 8'h00, 1'b1, 4'd7},
        '{1'b1, 1'b1, 1'b0, 7'd127, 8'h00, 8'h00, 1'b1, 4'd7},  // R7 top of window
        '{1'b0, 1'b0, 1'b0, 7'd9,   8'h00, 8'h00, 1'b0, 4'd4},  // R4 suppression before range
        '{1'b0, 1'b1, 1'b1, 7'd0,   8'h0F, 8'h00, 1'b0, 4'd2},  // R2 ones and zeros overwrite
        '{1'b0, 1'b1, 1'b0, 7'd0,   8'h00, 8'h0F, 1'b0, 4'd2},
        '{1'b0, 1'b1, 1'b0, 7'd5,   8'h00, 8'h00, 1'b0, 4'd7}   // R7 failed write left byte 5
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(grp == '0, "R1", "reset state", 128'(grp), 128'h0);
        chk(ng_grp == '0, "R1", "reset state ng", 128'(ng_grp), 128'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            acc_en = 1'b1; acc_cpu = VECS[k].cpu; acc_sec = VECS[k].sec;
            acc_wr = VECS[k].wr; acc_idx = VECS[k].idx; acc_wdata = VECS[k].wd;
            #2;
            chk(rd == VECS[k].exp_rd, $sformatf("R%0d", VECS[k].req),
                $sformatf("rdata vec %0d", k), 128'(rd), 128'(VECS[k].exp_rd));
            chk(err == VECS[k].exp_err, $sformatf("R%0d", VECS[k].req),
                $sformatf("err vec %0d", k), 128'(err), 128'(VECS[k].exp_err));
            chk(ng_rd == 8'h00 && !ng_err, "R8", $sformatf("no-group vec %0d", k),
                128'({ng_err, ng_rd}), 128'h0);
        end

        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        #2;
        chk(rd == 8'h00 && !err, "R3", "idle read data", 128'({err, rd}), 128'h0);
        chk(grp[7:0] == 8'h0F, "R2", "grp cpu0 IDs 0..7", 128'(grp[7:0]), 128'h0F);
        chk(grp[N_IRQ +: 8] == 8'h00, "R5", "grp cpu1 IDs 0..7", 128'(grp[N_IRQ +: 8]), 128'h0);
        chk(grp[N_IRQ+24 +: 8] == 8'h3C, "R5", "grp cpu1 IDs 24..31", 128'(grp[N_IRQ+24 +: 8]), 128'h3C);
        chk(grp[24 +: 8] == 8'h00, "R5", "grp cpu0 IDs 24..31", 128'(grp[24 +: 8]), 128'h0);
        chk(grp[32 +: 8] == 8'h81 && grp[N_IRQ+32 +: 8] == 8'h81, "R6", "grp IDs 32..39",
            128'({grp[N_IRQ+32 +: 8], grp[32 +: 8]}), 128'h8181);
        chk(grp[56 +: 8] == 8'hFF && grp[N_IRQ+56 +: 8] == 8'hFF, "R6", "grp IDs 56..63",
            128'({grp[N_IRQ+56 +: 8], grp[56 +: 8]}), 128'hFFFF);
        chk(ng_grp == '0, "R8", "no-group bits", 128'(ng_grp), 128'h0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(grp == '0, "R1", "second reset", 128'(grp), 128'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule